// File: doc/BRIEF.md
# Interval-Union Function Evaluator

This block evaluates K Boolean functions of an N-bit input at the same time. The input is read as an unsigned number. Each function is described by a set of closed intervals `[lo, hi]`, and it is 1 exactly when the input lies in at least one interval assigned to it. The interval bounds and the assignment of intervals to outputs are fixed at elaboration. They are given as a flat bound array and a K-by-M membership mask. Intervals may overlap, and one interval may feed several outputs.

The network has three layers.

- **Detection layer.** Each interval gets a detector built from two constant-bound magnitude comparators, one for each bound. Each comparator is a tree of radix-R (greater, equal) merge nodes. A comparator is left out when its bound is 0 or all ones.
- **Product-term path.** A short interval can instead be an aligned block of 2^s values. Such an interval is matched by a plain AND of the fixed upper input bits, which needs no comparator.
- **Output layer.** Each output ORs the detectors selected by its mask row.

The block is purely combinational and has no clock or reset. Valid/ready framing is left out because there is no storage in which a stall could be held. A user that needs a handshake registers the block's input and output.

Top module: `ivu_eval`

## Requirements
- R1: Output bit k equals 1 exactly when `in_value`, read as unsigned, satisfies lo_m <= in_value <= hi_m for at least one interval m whose membership bit (bit m of mask row k, flat index k*M+m) is set.
- R2: Both bounds of every interval are inclusive. The values lo and hi give 1 on the outputs that use that interval, and lo-1 and hi+1 do not, unless another assigned interval covers them.
- R3: When assigned intervals overlap, an input covered by several of them gives a 1 on the output, with no cancellation.
- R4: An output whose mask row is all zeros is 0 for every input value.
- R5: A lower bound of 0 or an upper bound of 2^N-1 drops the corresponding comparison, and the edge values 0 and 2^N-1 are still classified correctly.
- R6: The comparator tree with node radix R gives the unsigned result of x >= bound or x <= bound for every input, including when N is not a power of R.
- R7: An aligned interval with a power-of-two size below CUBE_MAX, including a single value, is matched by upper-bit equality. It gives the same function as the comparator form.
- R8: The outputs depend only on the present input. There is no register between `in_value` and `func_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_value | input | N | Value to classify, unsigned |
| func_out | output | K | One bit per function, 1 when the input lies in an assigned interval |

## Verification
The default configuration covers these cases:

- **Comparator form:**
  - an interval whose lower bound is 0;
  - a long interval that needs both comparators;
  - an interval whose upper bound is all ones.
- **Product-term form:**
  - an aligned block of 16 values;
  - a single value.
- **Overlap:** the single value lies inside a wider interval that feeds the same output.
- **Empty output:** one output has no intervals at all.

All 256 input values are swept. This sweep separates an off-by-one at any bound (R2, R5), a comparator tree that merges digits in the wrong order (R6), and a product-term mask that is too wide or too narrow (R7).

Directed cases then probe each bound and its two neighbours, and values inside the overlap (R3). Seeded random values are checked against the loop model a second time. Every value is checked a few nanoseconds after it is applied and with no clock edge in between, which makes any hidden register visible (R8).

// File: rtl/ivu_pkg.sv
package ivu_pkg;

  // Integer power, used to size padded comparator levels.
  function automatic int ipow(input int base, input int e);
    int acc;
    acc = 1;
    for (int i = 0; i < e; i++) acc = acc * base;
    return acc;
  endfunction

  // Number of radix-r merge levels needed to reduce n leaves to one.
  function automatic int tree_levels(input int n, input int r);
    int lvl;
    int span;
    lvl  = 0;
    span = 1;
    while (span < n) begin
      span = span * r;
      lvl++;
    end
    if (lvl == 0) lvl = 1;
    return lvl;
  endfunction

  // True when v is a non-zero power of two.
  function automatic bit is_pow2(input logic [63:0] v);
    return (v != 64'd0) && ((v & (v - 64'd1)) == 64'd0);
  endfunction

  // Selects the product-term form for a short, aligned interval.
  function automatic bit cube_form(input logic [63:0] lo, input logic [63:0] hi,
                                   input logic [63:0] cube_max);
    logic [63:0] sz;
    if (lo > hi) return 1'b0;
    sz = hi - lo + 64'd1;
    return is_pow2(sz) && ((lo & (sz - 64'd1)) == 64'd0) && (sz < cube_max);
  endfunction

endpackage

// File: rtl/ivu_cmp_node.sv
// Merges R (greater, equal) digit pairs into one pair. Index R-1 is the most
// significant digit.
module ivu_cmp_node #(
  parameter int R = 3
) (
  input  logic [R-1:0] gt_i,
  input  logic [R-1:0] eq_i,
  output logic         gt_o,
  output logic         eq_o
);

  always_comb begin
    logic acc_gt;
    logic acc_eq;
    acc_gt = 1'b0;
    acc_eq = 1'b1;
    for (int j = R - 1; j >= 0; j--) begin
      acc_gt = acc_gt | (acc_eq & gt_i[j]);
      acc_eq = acc_eq & eq_i[j];
    end
    gt_o = acc_gt;
    eq_o = acc_eq;
  end

  // A merged digit cannot be both greater and equal (R6).
  always_comb begin
    if (!$isunknown({gt_o, eq_o}))
      p_gt_eq_excl_r6: assert (!(gt_o && eq_o))
        else $error("node reports greater and equal together");
  end

endmodule

// File: rtl/ivu_mag_cmp.sv
// Compares x with a constant bound using a radix-R tree of merge nodes.
// MODE_GE=1 gives x >= BOUND, MODE_GE=0 gives x <= BOUND.
module ivu_mag_cmp
  import ivu_pkg::*;
#(
  parameter int           N       = 8,
  parameter int           R       = 3,
  parameter logic [N-1:0] BOUND   = '0,
  parameter bit           MODE_GE = 1'b1
) (
  input  logic [N-1:0] x,
  output logic         res
);

  localparam int L  = tree_levels(N, R);
  localparam int W0 = ipow(R, L);

  genvar s, j;
  for (s = 0; s <= L; s++) begin : g_lvl
    localparam int CNT = W0 / ipow(R, s);
    logic [CNT-1:0] gt;
    logic [CNT-1:0] eq;
    if (s == 0) begin : g_leaf
      for (j = 0; j < CNT; j++) begin : g_bit
        if (j < N) begin : g_real
          if (BOUND[j]) begin : g_one
            assign gt[j] = 1'b0;
            assign eq[j] = x[j];
          end else begin : g_zero
            assign gt[j] = x[j];
            assign eq[j] = ~x[j];
          end
        end else begin : g_pad
          // Leading zero digits of both operands compare equal.
          assign gt[j] = 1'b0;
          assign eq[j] = 1'b1;
        end
      end
    end else begin : g_merge
      for (j = 0; j < CNT; j++) begin : g_node
        ivu_cmp_node #(.R(R)) u_node (
          .gt_i (g_lvl[s-1].gt[j*R +: R]),
          .eq_i (g_lvl[s-1].eq[j*R +: R]),
          .gt_o (gt[j]),
          .eq_o (eq[j])
        );
      end
    end
  end

  logic top_gt;
  logic top_eq;
  assign top_gt = g_lvl[L].gt[0];
  assign top_eq = g_lvl[L].eq[0];

  if (MODE_GE) begin : g_ge
    assign res = top_gt | top_eq;
  end else begin : g_le
    assign res = ~top_gt | top_eq;
  end

  // The tree result matches a behavioural unsigned compare (R6).
  always_comb begin
    if (!$isunknown(x))
      p_tree_matches_r6: assert (res == (MODE_GE ? (x >= BOUND) : (x <= BOUND)))
        else $error("comparator tree mismatch for x=%0d", x);
  end

endmodule

// File: rtl/ivu_interval_det.sv
// Detects LO <= x <= HI, by an upper-bit match for short aligned blocks or
// by a pair of constant-bound comparators otherwise.
module ivu_interval_det
  import ivu_pkg::*;
#(
  parameter int           N        = 8,
  parameter int           R        = 3,
  parameter logic [N-1:0] LO       = '0,
  parameter logic [N-1:0] HI       = '1,
  parameter int           CUBE_MAX = 64
) (
  input  logic [N-1:0] x,
  output logic         hit
);

  localparam logic [63:0] LO64     = 64'(LO);
  localparam logic [63:0] HI64     = 64'(HI);
  localparam bit          USE_CUBE = cube_form(LO64, HI64, 64'(CUBE_MAX));
  localparam logic [63:0] SIZE64   = HI64 - LO64 + 64'd1;
  localparam logic [N-1:0] KEEP    = N'(~(SIZE64 - 64'd1));
  localparam bit          NEED_LO  = (LO != '0);
  localparam bit          NEED_HI  = (HI != '1);

  if (USE_CUBE) begin : g_cube
    // A block of 2^s values at an aligned base: only the upper bits are fixed.
    assign hit = (((x ^ LO) & KEEP) == '0);
  end else begin : g_range
    logic ge_lo;
    logic le_hi;
    if (NEED_LO) begin : g_lo
      ivu_mag_cmp #(.N(N), .R(R), .BOUND(LO), .MODE_GE(1'b1)) u_lo (
        .x   (x),
        .res (ge_lo)
      );
    end else begin : g_lo_const
      assign ge_lo = 1'b1;
    end
    if (NEED_HI) begin : g_hi
      ivu_mag_cmp #(.N(N), .R(R), .BOUND(HI), .MODE_GE(1'b0)) u_hi (
        .x   (x),
        .res (le_hi)
      );
    end else begin : g_hi_const
      assign le_hi = 1'b1;
    end
    if (!NEED_LO && !NEED_HI) begin : g_all
      // The interval covers the whole input space.
      assign hit = |{ge_lo & le_hi, x};
    end else begin : g_and
      assign hit = ge_lo & le_hi;
    end
  end

  // The detector fires exactly inside the closed interval (R2, R7).
  always_comb begin
    if (!$isunknown(x))
      p_hit_range_r2: assert (hit == ((x >= LO) && (x <= HI)))
        else $error("interval detector wrong for x=%0d", x);
  end

endmodule

// File: rtl/ivu_eval.sv
// Evaluates K functions, each a union of intervals selected by a mask row.
module ivu_eval #(
  parameter int               N        = 8,
  parameter int               K        = 4,
  parameter int               M        = 6,
  parameter int               R        = 3,
  parameter int               CUBE_MAX = 64,
  // Interval m occupies bits [m*N +: N].
  parameter logic [M*N-1:0]   LO_FLAT  = {8'd100, 8'd128, 8'd200, 8'd40, 8'd16, 8'd0},
  parameter logic [M*N-1:0]   HI_FLAT  = {8'd150, 8'd128, 8'd255, 8'd199, 8'd31, 8'd9},
  // Bit k*M+m assigns interval m to output k.
  parameter logic [K*M-1:0]   MEMBER   = {6'b000000, 6'b110001, 6'b000110, 6'b001001}
) (
  input  logic [N-1:0] in_value,
  output logic [K-1:0] func_out
);

  logic [M-1:0] hit;

  genvar m, k;
  for (m = 0; m < M; m++) begin : g_ivl
    ivu_interval_det #(
      .N        (N),
      .R        (R),
      .LO       (LO_FLAT[m*N +: N]),
      .HI       (HI_FLAT[m*N +: N]),
      .CUBE_MAX (CUBE_MAX)
    ) u_det (
      .x   (in_value),
      .hit (hit[m])
    );
  end

  for (k = 0; k < K; k++) begin : g_out
    localparam logic [M-1:0] ROW = MEMBER[k*M +: M];
    assign func_out[k] = |(hit & ROW);
  end

  // Each output equals the union of its intervals, recomputed from the bounds (R1).
  logic [K-1:0] model_out;
  always_comb begin
    model_out = '0;
    for (int kk = 0; kk < K; kk++)
      for (int mm = 0; mm < M; mm++)
        if (MEMBER[kk*M + mm] && in_value >= LO_FLAT[mm*N +: N] &&
            in_value <= HI_FLAT[mm*N +: N])
          model_out[kk] = 1'b1;
    if (!$isunknown(in_value))
      p_out_union_r1: assert (func_out == model_out)
        else $error("output union wrong for x=%0d", in_value);
  end

endmodule

// File: tb/test_ivu_eval.sv
module test_ivu_eval;

  localparam int N = 8;
  localparam int K = 4;
  localparam int M = 6;
  localparam logic [M*N-1:0] LO_F = {8'd100, 8'd128, 8'd200, 8'd40, 8'd16, 8'd0};
  localparam logic [M*N-1:0] HI_F = {8'd150, 8'd128, 8'd255, 8'd199, 8'd31, 8'd9};
  localparam logic [K*M-1:0] MEM  = {6'b000000, 6'b110001, 6'b000110, 6'b001001};

  logic         clk = 1'b0;
  logic [N-1:0] in_value = '0;
  logic [K-1:0] func_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ivu_eval #(
    .N(N), .K(K), .M(M), .R(3), .CUBE_MAX(64),
    .LO_FLAT(LO_F), .HI_FLAT(HI_F), .MEMBER(MEM)
  ) i_ivu_eval (
    .in_value (in_value),
    .func_out (func_out)
  );

  function automatic logic [K-1:0] ref_out(input logic [N-1:0] v);
    logic [K-1:0] r;
    r = '0;
    for (int k = 0; k < K; k++)
      for (int m = 0; m < M; m++)
        if (MEM[k*M + m] && v >= LO_F[m*N +: N] && v <= HI_F[m*N +: N]) r[k] = 1'b1;
    return r;
  endfunction

  task automatic chk(input logic [N-1:0] v, input string tag);
    logic [K-1:0] exp;
    @(negedge clk);
    in_value = v;
    #2;
    exp = ref_out(v);
    checks++;
    if (func_out !== exp) begin
      errors++;
      $display("FAIL %s x=%0d actual=%b expected=%b", tag, v, func_out, exp);
    end
  endtask

  task automatic chk_bit(input logic [N-1:0] v, input int k, input logic exp, input string tag);
    @(negedge clk);
    in_value = v;
    #2;
    checks++;
    if (func_out[k] !== exp) begin
      errors++;
      $display("FAIL %s x=%0d out%0d actual=%b expected=%b", tag, v, k, func_out[k], exp);
    end
  endtask

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd2024);
    // Initial value: input 0 lies only in [0,9] (R5)
    chk_bit(8'd0, 0, 1'b1, "R5");
    chk(8'd0, "R5");
    chk(8'd255, "R5");
    // Exhaustive sweep against the loop model (R1, R6)
    for (int v = 0; v < 256; v++) chk(N'(v), "R1");
    // Empty output stays 0 everywhere (R4)
    for (int v = 0; v < 256; v += 17) chk_bit(N'(v), 3, 1'b0, "R4");
    // Inclusive bounds and neighbours (R2)
    chk_bit(8'd9,   0, 1'b1, "R2");
    chk_bit(8'd10,  0, 1'b0, "R2");
    chk_bit(8'd39,  1, 1'b0, "R2");
    chk_bit(8'd40,  1, 1'b1, "R2");
    chk_bit(8'd199, 1, 1'b1, "R2");
    chk_bit(8'd199, 0, 1'b0, "R2");
    chk_bit(8'd200, 0, 1'b1, "R2");
    chk_bit(8'd150, 2, 1'b1, "R2");
    chk_bit(8'd151, 2, 1'b0, "R2");
    chk_bit(8'd99,  2, 1'b0, "R2");
    // Product-term intervals: [16,31] and the single value 128 (R7)
    chk_bit(8'd15,  1, 1'b0, "R7");
    chk_bit(8'd16,  1, 1'b1, "R7");
    chk_bit(8'd31,  1, 1'b1, "R7");
    chk_bit(8'd32,  1, 1'b0, "R7");
    chk(8'd127, "R7");
    chk(8'd129, "R7");
    // Overlap of 128 inside [100,150] on output 2 (R3)
    chk_bit(8'd128, 2, 1'b1, "R3");
    chk_bit(8'd120, 2, 1'b1, "R3");
    // Seeded random values, each checked a few ns after it is applied (R8)
    for (int i = 0; i < 300; i++) chk(N'($urandom), "R8");
    // Input changes with no clock edge in between (R8)
    in_value = 8'd5;
    #1;
    in_value = 8'd20;
    #1;
    checks++;
    if (func_out !== ref_out(8'd20)) begin
      errors++;
      $display("FAIL R8 x=20 actual=%b expected=%b", func_out, ref_out(8'd20));
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule